// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI controller in master mode. A word offered on the transmit handshake is loaded into a single shift register. It is clocked out on MOSI while MISO is sampled into the same register, and the finished word appears on the receive port as a one-cycle pulse. The serial clock is produced by a programmable divider, so one bit takes 2 × (BR + 1) module clocks.

The control inputs set the word length, clock polarity, clock phase, idle clock level, bit order, loopback and the two path-off switches. They are copied into the engine only while `en` is low and are frozen while it is high. The phase control is active-low relative to the usual CPHA: a 1 gives the variant that samples on the first edge of each bit. If a new transmit word is offered during the final half-period of the current word, it is taken on the last edge. The two words then run with no gap and `busy` stays high throughout.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, and whenever `en` is low, `busy`, `tx_ready`, `rx_valid` and `mosi` are 0.
- R2: Each half-period of SCLK lasts `cfg_br` + 1 module clocks. A word of N bits holds `busy` high for exactly 2·N·(`cfg_br` + 1) clocks.
- R3: The word length is `cfg_wlen` + 1 bits, and a field value of 0 is treated as 1, giving 2 bits. Transmit words use only bits [N-1:0]. Received words are right-aligned with the upper bits zero.
- R4: In a word, SCLK is at `cfg_pol` during even half-periods and inverted during odd ones. With `cfg_pha` = 1, MISO is sampled on the first edge of each bit and MOSI changes on the second. With `cfg_pha` = 0, MOSI changes on the first edge and MISO is sampled on the second.
- R5: Between words and while disabled, SCLK rests at `cfg_idle` and shows no edges.
- R6: `cfg_msb` = 1 shifts bit N-1 first. `cfg_msb` = 0 shifts bit 0 first. The same order applies to MOSI and MISO.
- R7: With `cfg_loop` = 1, the receive path takes the MOSI value and ignores the MISO pin.
- R8: With `cfg_tx_off` = 1, `tx_ready` stays 0 and MOSI stays 0. A word is started by `rx_req` when the receive path is on.
- R9: With `cfg_rx_off` = 1, no `rx_valid` pulse is produced, but words still shift out.
- R10: `busy` rises in the cycle after a word is accepted and falls on the cycle after its last edge. `rx_valid` pulses in that same cycle. A word accepted on the last edge continues `busy` with no gap.
- R11: Configuration inputs changed while `en` is high have no effect until `en` has been low.
- R12: Dropping `en` aborts a word in progress: `busy` falls on the next cycle, SCLK returns to idle and no received word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable; configuration is captured while low |
| cfg_br | input | 16 | Bit-rate divider value |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_pol | input | 1 | SCLK level in the first half of each bit |
| cfg_pha | input | 1 | 1: sample on first edge, 0: sample on second edge |
| cfg_idle | input | 1 | SCLK level between words |
| cfg_msb | input | 1 | 1: MSB first, 0: LSB first |
| cfg_loop | input | 1 | Internal MOSI-to-receive loopback |
| cfg_tx_off | input | 1 | Switch the transmit path off |
| cfg_rx_off | input | 1 | Switch the receive path off |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_ready | output | 1 | Transmit word taken at this clock edge |
| rx_req | input | 1 | Start a receive-only word when transmit is off |
| rx_valid | output | 1 | One-cycle pulse with a received word |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is shifting |

## Verification
On the last edge of a word, two things can happen in the same cycle. The finished receive word is extracted from the shift register, and the next transmit word is loaded into that same register. The bench provokes this by offering a second word while the first is still shifting, so the handshake lands on the final half-period. It then judges the outcome three ways. `busy` must stay high for exactly two word times with no gap. The first received word must match the bits the slave model drove. The slave model must capture the second transmit word intact from its very first bit.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    // Frozen mode bits, captured while the engine is disabled
    typedef struct packed {
        logic pol;
        logic pha;
        logic idle;
        logic msb;
        logic loop;
        logic tx_off;
        logic rx_off;
    } mode_t;

    localparam mode_t MODE_RESET = '0;

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
    parameter int BR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [BR_W-1:0] limit,
    output logic            tick
);

    typedef struct packed {
        logic [BR_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign tick = run && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (!run || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_eng_shreg.sv
module spi_eng_shreg #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              in_bit,
    input  logic              msb,
    input  logic [LEN_W-1:0]  lm1,
    output logic              out_bit,
    output logic [DATA_W-1:0] word_next
);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] shifted;

    assign mask    = {DATA_W{1'b1}} >> (LEN_W'(DATA_W - 1) - lm1);
    assign out_bit = msb ? st_q.sh[lm1] : st_q.sh[0];

    always_comb begin
        if (msb) begin
            shifted = {st_q.sh[DATA_W-2:0], in_bit};
        end else begin
            shifted      = st_q.sh >> 1;
            shifted[lm1] = in_bit;
        end
    end

    assign word_next = shifted & mask;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh = load_val & mask;
        end else if (shift) begin
            st_d.sh = word_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BR_W   = 16,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BR_W-1:0]   cfg_br,
    input  logic [LEN_W-1:0]  cfg_wlen,
    input  logic              cfg_pol,
    input  logic              cfg_pha,
    input  logic              cfg_idle,
    input  logic              cfg_msb,
    input  logic              cfg_loop,
    input  logic              cfg_tx_off,
    input  logic              cfg_rx_off,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_req,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);

    localparam int HALF_W = LEN_W + 1;

    typedef struct packed {
        logic [BR_W-1:0]   br;
        logic [LEN_W-1:0]  lm1;
        mode_t             mode;
        logic              act;
        logic [HALF_W-1:0] half;
        logic              samp;
        logic              rxv;
        logic [DATA_W-1:0] rxd;
    } st_t;

    localparam st_t ST_RESET = '{
        br:   '0,
        lm1:  LEN_W'(1),
        mode: MODE_RESET,
        act:  1'b0,
        half: '0,
        samp: 1'b0,
        rxv:  1'b0,
        rxd:  '0
    };

    st_t st_d, st_q;

    logic              tick;
    logic              last_half;
    logic              last_tick;
    logic              slot_free;
    logic              want;
    logic              start;
    logic              mosi_int;
    logic              rx_in;
    logic              sample_now;
    logic              shift_now;
    logic              sh_shift;
    logic              sh_in;
    logic              sh_out;
    logic [DATA_W-1:0] sh_word;
    logic [DATA_W-1:0] load_val;

    // Bit-rate generator: one tick per half-period
    spi_eng_baud #(
        .BR_W (BR_W)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.act & en),
        .restart (start),
        .limit   (st_q.br),
        .tick    (tick)
    );

    // Single register serves both directions
    spi_eng_shreg #(
        .DATA_W (DATA_W)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_val  (load_val),
        .shift     (sh_shift),
        .in_bit    (sh_in),
        .msb       (st_q.mode.msb),
        .lm1       (st_q.lm1),
        .out_bit   (sh_out),
        .word_next (sh_word)
    );

    // Word boundary and acceptance
    assign last_half = (st_q.half == {st_q.lm1, 1'b1});
    assign last_tick = tick & last_half;
    assign slot_free = en & (~st_q.act | last_tick);
    assign want      = st_q.mode.tx_off ? (~st_q.mode.rx_off & rx_req) : tx_valid;
    assign start     = slot_free & want;
    assign load_val  = st_q.mode.tx_off ? '0 : tx_data;

    // Serial data paths
    assign mosi_int  = st_q.act & ~st_q.mode.tx_off & sh_out;
    assign rx_in     = st_q.mode.loop ? mosi_int : miso;

    // Edge roles: pha=1 samples on even halves, pha=0 on odd halves
    assign sample_now = st_q.mode.pha ? ~st_q.half[0] : st_q.half[0];
    always_comb begin
        if (st_q.mode.pha) begin
            shift_now = st_q.half[0];
        end else if (st_q.half[0]) begin
            shift_now = last_half;
        end else begin
            shift_now = (st_q.half != '0);
        end
    end
    assign sh_shift = tick & shift_now;
    assign sh_in    = (last_half & ~st_q.mode.pha) ? rx_in : st_q.samp;

    always_comb begin
        st_d     = st_q;
        st_d.rxv = 1'b0;
        if (!en) begin
            st_d.br   = cfg_br;
            st_d.lm1  = (cfg_wlen == '0) ? LEN_W'(1) : cfg_wlen;
            st_d.mode = '{
                pol:    cfg_pol,
                pha:    cfg_pha,
                idle:   cfg_idle,
                msb:    cfg_msb,
                loop:   cfg_loop,
                tx_off: cfg_tx_off,
                rx_off: cfg_rx_off
            };
            st_d.act  = 1'b0;
            st_d.half = '0;
        end else begin
            if (tick) begin
                if (sample_now) begin
                    st_d.samp = rx_in;
                end
                if (last_half) begin
                    st_d.act  = 1'b0;
                    st_d.half = '0;
                    if (!st_q.mode.rx_off) begin
                        st_d.rxv = 1'b1;
                        st_d.rxd = sh_word;
                    end
                end else begin
                    st_d.half = st_q.half + 1'b1;
                end
            end
            if (start) begin
                st_d.act  = 1'b1;
                st_d.half = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready = en & ~st_q.mode.tx_off & (~st_q.act | last_tick);
    assign rx_valid = st_q.rxv;
    assign rx_data  = st_q.rxd;
    assign sclk     = st_q.act ? (st_q.mode.pol ^ st_q.half[0]) : st_q.mode.idle;
    assign mosi     = mosi_int;
    assign busy     = st_q.act;

endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker
    import spi_eng_pkg::*;
#(
    parameter int BR_W  = 16,
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             sclk,
    input logic             mosi,
    input logic             busy,
    input logic [BR_W-1:0]  br_q,
    input logic [LEN_W-1:0] lm1_q,
    input mode_t            mode_q
);

    // R3: a one-bit word is never configured
    assert_min_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> lm1_q != '0);

    // R5: no SCLK edges while idle and enabled
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && !busy && !$past(busy) |-> $stable(sclk));

    // R8: transmit path off keeps MOSI low and refuses words
    assert_tx_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_q.tx_off |-> !mosi && !tx_ready);

    // R9: receive path off never reports a word
    assert_no_rx_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.rx_off && $past(mode_q.rx_off) |-> !rx_valid);

    // R10: an accepted word makes the engine busy
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> busy);

    // R10: a result follows a busy period
    assert_result_after_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy));

    // R11: configuration frozen while enabled
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) |-> $stable(br_q) && $stable(lm1_q) && $stable(mode_q));

    // R12: disabling ends activity on the next cycle
    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy && !rx_valid);

endmodule

bind spi_shift_engine spi_eng_checker #(
    .BR_W  (BR_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .sclk     (sclk),
    .mosi     (mosi),
    .busy     (busy),
    .br_q     (st_q.br),
    .lm1_q    (st_q.lm1),
    .mode_q   (st_q.mode)
);

// File: tb/sim_spi_shift_engine.sv
module sim_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] cfg_br = '0;
    logic [4:0]  cfg_wlen = 5'd7;
    logic        cfg_pol = 1'b0, cfg_pha = 1'b1, cfg_idle = 1'b0, cfg_msb = 1'b1;
    logic        cfg_loop = 1'b0, cfg_tx_off = 1'b0, cfg_rx_off = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_req = 1'b0;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        sclk, mosi, busy;
    logic        miso = 1'b0;

    always #10 clk = ~clk;

    spi_shift_engine u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_br(cfg_br), .cfg_wlen(cfg_wlen),
        .cfg_pol(cfg_pol), .cfg_pha(cfg_pha), .cfg_idle(cfg_idle), .cfg_msb(cfg_msb),
        .cfg_loop(cfg_loop), .cfg_tx_off(cfg_tx_off), .cfg_rx_off(cfg_rx_off),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_req(rx_req),
        .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
        .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench view of the configuration
    int    b_len = 8;
    int    b_br = 0;
    bit    b_cpha = 0, b_msb = 1, b_loop = 0, b_txoff = 0, b_rxoff = 0;
    bit    b_chk = 1;
    string b_tag = "R4";

    logic [31:0] exp_rx_q[$];
    logic [31:0] exp_mosi_q[$];
    logic [31:0] slave_q[$];

    int busy_run = 0, last_len = 0, falls = 0, edge_n = 0;
    logic prev_sclk = 1'b0, prev_busy = 1'b0, prev_mosi = 1'b0;
    logic [31:0] cap = '0;

    function automatic logic [31:0] len_mask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    function automatic int bitpos(int k);
        return b_msb ? (b_len - 1 - k) : k;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor and slave model, all away from the active edge
    always @(negedge clk) begin
        if (busy) busy_run++;
        else if (prev_busy) begin
            last_len = busy_run;
            busy_run = 0;
            falls++;
        end
        if (rx_valid) begin
            if (exp_rx_q.size() == 0) chk(0, "R9 R12", "unexpected rx word", rx_data, 0);
            else begin
                logic [31:0] e;
                e = exp_rx_q.pop_front();
                chk(rx_data == e, b_tag, "rx word", rx_data, e);
            end
        end
        if (!en) begin
            edge_n = 0;
            cap = '0;
        end else if ((busy || prev_busy) && sclk != prev_sclk) begin
            edge_n++;
            if (!b_cpha) begin
                if (edge_n % 2 == 1) cap[bitpos((edge_n - 1) / 2)] = prev_mosi;
                else if (edge_n < 2 * b_len && slave_q.size() > 0)
                    miso = slave_q[0][bitpos(edge_n / 2)];
            end else begin
                if (edge_n % 2 == 0) cap[bitpos(edge_n / 2 - 1)] = prev_mosi;
                else if (slave_q.size() > 0)
                    miso = slave_q[0][bitpos((edge_n - 1) / 2)];
            end
            if (edge_n == 2 * b_len) begin
                if (b_chk && exp_mosi_q.size() > 0) begin
                    logic [31:0] e;
                    e = exp_mosi_q.pop_front();
                    chk(cap == e, b_tag, "word seen on MOSI", cap, e);
                end
                if (slave_q.size() > 0) void'(slave_q.pop_front());
                edge_n = 0;
                cap = '0;
            end
        end
        if (edge_n == 0 && slave_q.size() > 0) miso = slave_q[0][bitpos(0)];
        prev_sclk = sclk;
        prev_busy = busy;
        prev_mosi = mosi;
    end

    task automatic configure(int wl, bit pol, bit cpha, bit idl, bit msb, bit loop,
                             bit txoff, bit rxoff, int br);
        @(negedge clk);
        en = 1'b0;
        cfg_wlen = 5'(wl); cfg_pol = pol; cfg_pha = ~cpha; cfg_idle = idl;
        cfg_msb = msb; cfg_loop = loop; cfg_tx_off = txoff; cfg_rx_off = rxoff;
        cfg_br = 16'(br);
        b_len = (wl == 0) ? 2 : wl + 1;
        b_br = br; b_cpha = cpha; b_msb = msb; b_loop = loop; b_txoff = txoff; b_rxoff = rxoff;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // Driver: push expectations, then hand the word over
    task automatic send(logic [31:0] d, logic [31:0] s);
        logic [31:0] m, txw;
        m = len_mask(b_len);
        txw = b_txoff ? 32'h0 : (d & m);
        if (b_chk) begin
            exp_mosi_q.push_back(txw);
            slave_q.push_back(s);
            if (!b_rxoff) exp_rx_q.push_back(b_loop ? txw : (s & m));
        end
        @(negedge clk);
        if (b_txoff) begin
            rx_req = 1'b1;
            while (busy) @(negedge clk);
        end else begin
            tx_valid = 1'b1;
            tx_data = d;
            while (!tx_ready) @(negedge clk);
        end
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
        rx_req = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic one_word(logic [31:0] d, logic [31:0] s);
        send(d, s);
        wait_done();
        chk(last_len == 2 * b_len * (b_br + 1), "R2", "busy length", last_len,
            2 * b_len * (b_br + 1));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and disabled state
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(tx_ready == 0, "R1", "tx_ready while disabled", tx_ready, 0);
        chk(rx_valid == 0, "R1", "rx_valid after reset", rx_valid, 0);
        chk(mosi == 0, "R1", "mosi after reset", mosi, 0);

        // R4 R6: four clock modes, MSB first, external slave
        b_tag = "R4 mode0";
        configure(7, 0, 0, 0, 1, 0, 0, 0, 1);
        one_word(32'hA5, 32'h3C);
        one_word(32'h0F, 32'hF0);
        b_tag = "R4 mode1";
        configure(7, 0, 1, 0, 1, 0, 0, 0, 1);
        one_word(32'h96, 32'h5A);
        b_tag = "R4 mode2";
        configure(7, 1, 0, 1, 1, 0, 0, 0, 2);
        one_word(32'hC3, 32'h81);
        b_tag = "R4 mode3";
        configure(7, 1, 1, 1, 1, 0, 0, 0, 0);
        one_word(32'h12, 32'hED);

        // R6: LSB first
        b_tag = "R6 lsb mode0";
        configure(7, 0, 0, 0, 0, 0, 0, 0, 1);
        one_word(32'h01, 32'h80);
        b_tag = "R6 lsb mode3";
        configure(7, 1, 1, 1, 0, 0, 0, 0, 0);
        one_word(32'hB4, 32'h2D);

        // R3: lengths, alignment and the zero field
        b_tag = "R3 16bit";
        configure(15, 0, 0, 0, 1, 0, 0, 0, 0);
        one_word(32'hDEAD_BEEF, 32'h1234_ABCD);
        b_tag = "R3 32bit";
        configure(31, 0, 1, 0, 0, 0, 0, 0, 3);
        one_word(32'hCAFE_F00D, 32'h8000_0001);
        b_tag = "R3 5bit";
        configure(4, 0, 0, 0, 1, 0, 0, 0, 0);
        one_word(32'hFFFF_FFFF, 32'hFFFF_FFF5);
        b_tag = "R3 field0";
        configure(0, 0, 0, 0, 1, 0, 0, 0, 1);
        one_word(32'h2, 32'hFFFF_FFFD);

        // R7: loopback ignores the slave
        b_tag = "R7 loop";
        configure(7, 0, 0, 0, 1, 1, 0, 0, 1);
        one_word(32'h5C, 32'hA3);
        configure(15, 1, 1, 1, 0, 1, 0, 0, 0);
        one_word(32'h8001, 32'h7FFE);

        // R8: transmit off, receive-only words
        b_tag = "R8 tx off";
        configure(7, 0, 0, 0, 1, 0, 1, 0, 1);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = 32'hFF;
        repeat (3) @(negedge clk);
        chk(tx_ready == 0 && busy == 0, "R8", "tx_valid ignored with transmit off",
            {30'd0, tx_ready, busy}, 0);
        tx_valid = 1'b0;
        one_word(32'hFF, 32'h6B);
        configure(7, 0, 0, 0, 1, 1, 1, 0, 0);
        one_word(32'hFF, 32'hFF);

        // R9: receive off, transmission still observed
        b_tag = "R9 rx off";
        configure(7, 0, 0, 0, 1, 0, 0, 1, 1);
        one_word(32'h3E, 32'hC1);

        // R10: back-to-back words, load and finish in the same cycle
        b_tag = "R10 back-to-back";
        configure(7, 0, 0, 0, 1, 0, 0, 0, 0);
        begin
            int f0;
            f0 = falls;
            send(32'hA1, 32'h5E);
            send(32'h7B, 32'h84);
            wait_done();
            chk(last_len == 2 * 2 * b_len * (b_br + 1), "R10", "continuous busy length",
                last_len, 2 * 2 * b_len * (b_br + 1));
            chk(falls - f0 == 1, "R10", "busy falls once for two words", falls - f0, 1);
        end

        // R11: divider change while enabled has no effect
        b_tag = "R11 frozen";
        configure(7, 0, 0, 0, 1, 0, 0, 0, 1);
        @(negedge clk);
        cfg_br = 16'd5;
        cfg_wlen = 5'd3;
        one_word(32'h66, 32'h99);

        // R5: idle level separate from polarity
        b_chk = 0;
        b_tag = "R5 idle";
        configure(7, 0, 0, 1, 1, 0, 0, 1, 2);
        @(negedge clk);
        chk(sclk == 1, "R5", "idle level while enabled", sclk, 1);
        send(32'h55, 32'h00);
        chk(sclk == 0, "R4", "first half level equals polarity", sclk, 0);
        wait_done();
        chk(sclk == 1, "R5", "idle level after word", sclk, 1);

        // R12: abort by disabling
        b_tag = "R12 abort";
        configure(31, 0, 0, 0, 1, 0, 0, 0, 3);
        send(32'h1234_5678, 32'h0);
        repeat (20) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R12", "busy after disable", busy, 0);
        chk(sclk == 0, "R12", "sclk back to idle", sclk, 0);
        repeat (300) @(negedge clk);
        chk(rx_valid == 0 && exp_rx_q.size() == 0, "R12", "no result after abort",
            rx_valid, 0);
        slave_q.delete();
        b_chk = 1;

        chk(exp_rx_q.size() == 0, "R10", "all results delivered", exp_rx_q.size(), 0);
        chk(exp_mosi_q.size() == 0, "R4", "all words observed", exp_mosi_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule